// File: doc/BRIEF.md
# Keyed Watchdog Timer with Pretimeout Stage

This block is a countdown watchdog driven by a slow periodic tick (nominally 32 kHz) on top of the system clock. Software sets a timeout length through a small 32-bit register bus, enables the counter and must then write a reload word at regular intervals. If the count runs out, the block raises an interrupt, requests a system reset, or does both in turn, depending on its mode bits. In the two-stage mode the first expiry raises the interrupt and starts a new countdown. A second expiry with no reload in between requests the reset.

Every write that changes behaviour must carry a magic value in the written word. The mode register needs a key byte in its top bits. The length register needs a key pattern in its low bits. The reload and software-reset registers act only on one exact 32-bit word each. A write with a wrong key leaves the block as it was. A reset request gives a one-clock pulse on an internal request line. It also gives a stretched pulse on an external pin, whose active level can be programmed and which can be kept idle.

Top module: `keyed_wdog`

## Requirements
- R1: A write to offset 0x00 updates the mode only when bits 31:24 equal 0x22; otherwise the mode is unchanged. The mode bits are: enable bit 0, external polarity-high bit 1, external pin enable bit 2, interrupt enable bit 3, auto-start bit 4, two-stage bit 6, counter select bit 8. Reading offset 0x00 returns only these bits, with all other bits zero.
- R2: A write to offset 0x04 updates the length only when bits 4:0 equal 0x08; the length field occupies bits starting at bit 5. Reading offset 0x04 returns the length at bit 5 upward with bits 4:0 zero. A keyed length write also restarts the countdown from the new length.
- R3: While enabled, an expiry occurs on the (length × UNIT_TICKS)-th tick after the last restart; a length of zero expires on the first tick. After each expiry the countdown restarts from the stored length.
- R4: Writing exactly 0x1971 to offset 0x08 restarts the countdown; any other value written there has no effect.
- R5: With interrupt enable set and two-stage clear, an expiry sets irq_o and issues no reset request. irq_o remains set through further expiries.
- R6: With interrupt enable clear, each expiry produces a one-clock pulse on rst_req_o.
- R7: With interrupt enable and two-stage both set, the first expiry sets irq_o. The next expiry with no restart in between pulses rst_req_o and clears irq_o.
- R8: Writing exactly 0x1209 to offset 0x14 pulses rst_req_o in the next clock, whether or not the counter is enabled; any other value there has no effect.
- R9: ext_rst_o rests at the inverse of the polarity bit. When the external pin enable is set, every reset request drives it to the polarity bit's level for PULSE_TICKS ticks. When the enable is clear, it never leaves the resting level.
- R10: While the enable bit is clear, ticks do not count, irq_o is low and no expiry occurs.
- R11: A restart (reload word, keyed length write or enabling) clears irq_o and returns the two-stage sequence to its first stage.
- R12: Setting the enable bit when it was clear restarts the countdown from the stored length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-clock pulse per slow tick |
| addr_i | input | ADDR_W | Register byte offset |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | 1 | Pretimeout interrupt, level |
| rst_req_o | output | 1 | One-clock reset request |
| ext_rst_o | output | 1 | External reset pin, programmable level |

## Verification
The bench sweeps every length from 0 to 5 in the interrupt-only mode and the reset mode, and counts the ticks to expiry against length × UNIT_TICKS. A counter that is off by one tick, or that treats length zero as an enormous count, shows up here as a wrong tick count. The two-stage test checks that the reset comes only after the second full interval. A design that resets on the first expiry, or never clears its stage, fails this test. Near-miss keys (0x21 in the mode key byte, a low nibble of 0x09, reload 0x1970, reset 0x1208) must leave the block unchanged. The external pin is timed tick by tick under both polarities and with the pin disabled, so a pulse one tick short or long, or a wrong polarity, is reported.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

    localparam int OFS_MODE  = 'h00;
    localparam int OFS_LEN   = 'h04;
    localparam int OFS_KICK  = 'h08;
    localparam int OFS_SWRST = 'h14;

    localparam logic [7:0]  MODE_KEY  = 8'h22;
    localparam logic [4:0]  LEN_KEY   = 5'h08;
    localparam logic [31:0] KICK_WORD = 32'h0000_1971;
    localparam logic [31:0] SWRST_WORD = 32'h0000_1209;

    localparam int LEN_LSB = 5;

    typedef struct packed {
        logic cnt_sel;
        logic dual;
        logic auto_start;
        logic irq_en;
        logic ext_en;
        logic ext_pol;
        logic en;
    } mode_t;

endpackage

// File: rtl/kwd_regs.sv
module kwd_regs
    import kwd_pkg::*;
#(
    parameter int LEN_W  = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    output logic              en_o,
    output logic              irq_en_o,
    output logic              dual_o,
    output logic              ext_en_o,
    output logic              ext_pol_o,
    output logic [LEN_W-1:0]  len_q_o,
    output logic [LEN_W-1:0]  len_d_o,
    output logic              restart_o,
    output logic              swrst_o
);

    typedef struct packed {
        mode_t            mode;
        logic [LEN_W-1:0] len;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  hit_mode, hit_len, hit_kick, hit_swrst;
    logic  len_wr, kick;

    always_comb begin
        regs_d    = regs_q;
        hit_mode  = we_i && (addr_i == ADDR_W'(OFS_MODE));
        hit_len   = we_i && (addr_i == ADDR_W'(OFS_LEN));
        hit_kick  = we_i && (addr_i == ADDR_W'(OFS_KICK));
        hit_swrst = we_i && (addr_i == ADDR_W'(OFS_SWRST));
        len_wr    = hit_len && (wdata_i[4:0] == LEN_KEY);
        kick      = hit_kick && (wdata_i == KICK_WORD);

        if (hit_mode && (wdata_i[31:24] == MODE_KEY)) begin
            regs_d.mode.en         = wdata_i[0];
            regs_d.mode.ext_pol    = wdata_i[1];
            regs_d.mode.ext_en     = wdata_i[2];
            regs_d.mode.irq_en     = wdata_i[3];
            regs_d.mode.auto_start = wdata_i[4];
            regs_d.mode.dual       = wdata_i[6];
            regs_d.mode.cnt_sel    = wdata_i[8];
        end
        if (len_wr) begin
            regs_d.len = wdata_i[LEN_LSB +: LEN_W];
        end

        restart_o = kick || len_wr || (regs_d.mode.en && !regs_q.mode.en);
        swrst_o   = hit_swrst && (wdata_i == SWRST_WORD);

        rdata_o = '0;
        if (addr_i == ADDR_W'(OFS_MODE)) begin
            rdata_o = {23'd0, regs_q.mode.cnt_sel, 1'b0, regs_q.mode.dual, 1'b0,
                       regs_q.mode.auto_start, regs_q.mode.irq_en, regs_q.mode.ext_en,
                       regs_q.mode.ext_pol, regs_q.mode.en};
        end else if (addr_i == ADDR_W'(OFS_LEN)) begin
            rdata_o = 32'(regs_q.len) << LEN_LSB;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign en_o      = regs_q.mode.en;
    assign irq_en_o  = regs_q.mode.irq_en;
    assign dual_o    = regs_q.mode.dual;
    assign ext_en_o  = regs_q.mode.ext_en;
    assign ext_pol_o = regs_q.mode.ext_pol;
    assign len_q_o   = regs_q.len;
    assign len_d_o   = regs_d.len;

    // R1: a mode write with the wrong key byte changes nothing
    a_r1_mode_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && addr_i == ADDR_W'(OFS_MODE) && wdata_i[31:24] != MODE_KEY)
        |=> $stable(regs_q.mode));

    // R2: a length write with the wrong low key bits changes nothing
    a_r2_len_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && addr_i == ADDR_W'(OFS_LEN) && wdata_i[4:0] != LEN_KEY)
        |=> $stable(regs_q.len));

endmodule

// File: rtl/kwd_count.sv
module kwd_count #(
    parameter int LEN_W      = 16,
    parameter int UNIT_TICKS = 512
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             en_i,
    input  logic             irq_en_i,
    input  logic             dual_i,
    input  logic [LEN_W-1:0] len_cur_i,
    input  logic [LEN_W-1:0] len_next_i,
    input  logic             restart_i,
    input  logic             swrst_i,
    output logic             irq_o,
    output logic             rst_req_o
);

    localparam int CNT_W = LEN_W + $clog2(UNIT_TICKS + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             irq;
        logic             stage;
        logic             rst_req;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic [CNT_W-1:0] load_cur, load_next;
    logic             expire;

    always_comb begin
        load_cur  = CNT_W'(len_cur_i) * CNT_W'(UNIT_TICKS);
        load_next = CNT_W'(len_next_i) * CNT_W'(UNIT_TICKS);
        expire    = en_i && tick_i && (st_q.cnt <= CNT_W'(1));

        st_d         = st_q;
        st_d.rst_req = 1'b0;

        if (!en_i) begin
            st_d.irq   = 1'b0;
            st_d.stage = 1'b0;
        end else if (tick_i) begin
            if (expire) begin
                st_d.cnt = load_cur;
                if (!irq_en_i) begin
                    st_d.rst_req = 1'b1;
                    st_d.stage   = 1'b0;
                end else if (!dual_i) begin
                    st_d.irq = 1'b1;
                end else if (!st_q.stage) begin
                    st_d.irq   = 1'b1;
                    st_d.stage = 1'b1;
                end else begin
                    st_d.rst_req = 1'b1;
                    st_d.irq     = 1'b0;
                    st_d.stage   = 1'b0;
                end
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end

        if (restart_i) begin
            st_d.cnt   = load_next;
            st_d.irq   = 1'b0;
            st_d.stage = 1'b0;
        end
        if (swrst_i) begin
            st_d.rst_req = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o     = st_q.irq;
    assign rst_req_o = st_q.rst_req;

    // R10: disabled counter drops the interrupt on the next clock
    a_r10_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> !st_q.irq);

    // R4: a restart loads the count from the new length
    a_r4_restart_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restart_i |=> (st_q.cnt == $past(load_next)));

    // R8: keyed software reset yields a request next clock
    a_r8_swrst_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
        swrst_i |=> st_q.rst_req);

    // R7: an expiry reset only when interrupts are off or the second stage is reached
    a_r7_reset_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.rst_req && !$past(swrst_i))
        |-> $past(!irq_en_i || (dual_i && st_q.stage)));

    // R5: interrupt-only mode never requests a reset from an expiry
    a_r5_irq_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_en_i && !dual_i && !swrst_i) |=> !st_q.rst_req);

endmodule

// File: rtl/kwd_pulse.sv
module kwd_pulse #(
    parameter int PULSE_TICKS = 32
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic start_i,
    output logic active_o
);

    localparam int PW = $clog2(PULSE_TICKS + 1);

    typedef struct packed {
        logic [PW-1:0] left;
    } pulse_st_t;

    pulse_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.left = PW'(PULSE_TICKS);
        end else if (tick_i && st_q.left != '0) begin
            st_d.left = st_q.left - PW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = (st_q.left != '0);

    // R9: the pulse only begins after a reset request
    a_r9_pulse_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(active_o) |-> $past(start_i));

    // R9: remaining length never exceeds the programmed width
    a_r9_pulse_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.left <= PW'(PULSE_TICKS));

endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog #(
    parameter int LEN_W       = 16,
    parameter int UNIT_TICKS  = 512,
    parameter int PULSE_TICKS = 32,
    parameter int ADDR_W      = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    output logic              irq_o,
    output logic              rst_req_o,
    output logic              ext_rst_o
);

    logic             en, irq_en, dual, ext_en, ext_pol;
    logic [LEN_W-1:0] len_q, len_d;
    logic             restart, swrst, pulse_on;

    kwd_regs #(
        .LEN_W (LEN_W),
        .ADDR_W(ADDR_W)
    ) i_regs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .addr_i   (addr_i),
        .we_i     (we_i),
        .wdata_i  (wdata_i),
        .rdata_o  (rdata_o),
        .en_o     (en),
        .irq_en_o (irq_en),
        .dual_o   (dual),
        .ext_en_o (ext_en),
        .ext_pol_o(ext_pol),
        .len_q_o  (len_q),
        .len_d_o  (len_d),
        .restart_o(restart),
        .swrst_o  (swrst)
    );

    kwd_count #(
        .LEN_W     (LEN_W),
        .UNIT_TICKS(UNIT_TICKS)
    ) i_count (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick_i),
        .en_i      (en),
        .irq_en_i  (irq_en),
        .dual_i    (dual),
        .len_cur_i (len_q),
        .len_next_i(len_d),
        .restart_i (restart),
        .swrst_i   (swrst),
        .irq_o     (irq_o),
        .rst_req_o (rst_req_o)
    );

    kwd_pulse #(
        .PULSE_TICKS(PULSE_TICKS)
    ) i_pulse (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (tick_i),
        .start_i (rst_req_o),
        .active_o(pulse_on)
    );

    assign ext_rst_o = (ext_en && pulse_on) ? ext_pol : !ext_pol;

endmodule

// File: tb/test_keyed_wdog.sv
module test_keyed_wdog;

    localparam int CLK_PERIOD = 10;
    localparam int LW = 6;
    localparam int UT = 4;
    localparam int PT = 5;

    localparam logic [31:0] MK   = 32'h2200_0000;
    localparam logic [31:0] M_EN = 32'h001;
    localparam logic [31:0] M_PH = 32'h002;
    localparam logic [31:0] M_XE = 32'h004;
    localparam logic [31:0] M_IE = 32'h008;
    localparam logic [31:0] M_DU = 32'h040;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [7:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, rst_req, ext_rst;

    int n_chk = 0;
    int n_bad = 0;
    int rst_cnt = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    keyed_wdog #(
        .LEN_W(LW), .UNIT_TICKS(UT), .PULSE_TICKS(PT), .ADDR_W(8)
    ) i_keyed_wdog (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .addr_i(addr), .we_i(we),
        .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .rst_req_o(rst_req),
        .ext_rst_o(ext_rst)
    );

    always @(negedge clk) if (rst_n && rst_req) rst_cnt++;

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0; addr = 8'h00;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic tick1();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick1();
    endtask

    task automatic setup(input int len, input logic [31:0] mode);
        wr(8'h00, MK);
        wr(8'h04, (32'(len) << 5) | 32'h8);
        wr(8'h00, MK | mode);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        int got, base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        rd(8'h00, r); chk("R1 reset mode", r, 0);
        rd(8'h04, r); chk("R2 reset len", r, 0);
        chk("R10 reset irq", irq, 0);
        chk("R9 reset pin idle high", ext_rst, 1);

        // R1 readback and key
        wr(8'h00, 32'h2200_FFFE);
        rd(8'h00, r); chk("R1 mode mask", r, 32'h15E);
        wr(8'h00, 32'h2100_0000);
        rd(8'h00, r); chk("R1 bad key ignored", r, 32'h15E);
        wr(8'h00, MK);
        rd(8'h00, r); chk("R1 keyed clear", r, 0);

        // R2 readback and key
        wr(8'h04, (32'd5 << 5) | 32'h8);
        rd(8'h04, r); chk("R2 len readback", r, 32'hA0);
        wr(8'h04, (32'd7 << 5) | 32'h9);
        rd(8'h04, r); chk("R2 bad key ignored", r, 32'hA0);

        // R3 / R5 / R12: ticks to interrupt for each length
        for (int l = 0; l <= 5; l++) begin
            setup(l, M_EN | M_IE);
            got = 0;
            for (int n = 1; n <= 30; n++) begin
                tick1();
                if (irq) begin got = n; break; end
            end
            chk($sformatf("R3 irq ticks len %0d", l), got, (l == 0) ? 1 : l * UT);
        end

        // R3 / R6: ticks to reset request for each length
        for (int l = 0; l <= 5; l++) begin
            setup(l, M_EN);
            base = rst_cnt;
            got = 0;
            for (int n = 1; n <= 30; n++) begin
                tick1();
                if (rst_cnt != base) begin got = n; break; end
            end
            chk($sformatf("R6 reset ticks len %0d", l), got, (l == 0) ? 1 : l * UT);
            chk($sformatf("R6 single pulse len %0d", l), rst_cnt - base, 1);
            chk($sformatf("R6 no irq len %0d", l), irq, 0);
        end

        // R6 / R3: counting restarts after a reset expiry
        setup(1, M_EN);
        base = rst_cnt;
        ticks(2 * UT);
        chk("R3 two expiries", rst_cnt - base, 2);

        // R5: interrupt stays, no reset
        setup(2, M_EN | M_IE);
        base = rst_cnt;
        ticks(3 * 2 * UT);
        chk("R5 irq sticky", irq, 1);
        chk("R5 no reset", rst_cnt - base, 0);

        // R4 / R11: reload behaviour
        setup(2, M_EN | M_IE);
        ticks(6);
        wr(8'h08, 32'h1971);
        ticks(6);
        chk("R4 reload delays irq", irq, 0);
        wr(8'h08, 32'h1970);
        ticks(2);
        chk("R4 bad reload ignored", irq, 1);
        wr(8'h08, 32'h1971);
        chk("R11 reload clears irq", irq, 0);
        wr(8'h04, (32'd3 << 5) | 32'h8);
        ticks(11);
        chk("R2 len write restarts", irq, 0);
        tick1();
        chk("R2 new length used", irq, 1);

        // R7: two-stage sequence
        setup(2, M_EN | M_IE | M_DU);
        base = rst_cnt;
        ticks(2 * UT);
        chk("R7 first stage irq", irq, 1);
        chk("R7 first stage no reset", rst_cnt - base, 0);
        ticks(2 * UT - 1);
        chk("R7 not early", rst_cnt - base, 0);
        tick1();
        chk("R7 second stage reset", rst_cnt - base, 1);
        chk("R7 irq cleared", irq, 0);
        ticks(2 * UT);
        chk("R7 restarted stage irq", irq, 1);
        wr(8'h08, 32'h1971);
        ticks(2 * UT);
        chk("R11 stage reset by reload", rst_cnt - base, 1);
        chk("R11 stage irq again", irq, 1);

        // R10: disable
        setup(1, M_EN | M_IE);
        ticks(2);
        wr(8'h00, MK | M_IE);
        base = rst_cnt;
        ticks(20);
        chk("R10 irq low disabled", irq, 0);
        chk("R10 no reset disabled", rst_cnt - base, 0);
        setup(1, M_EN | M_IE);
        ticks(2);
        wr(8'h00, MK | M_IE);
        wr(8'h00, MK | M_EN | M_IE);
        ticks(UT - 1);
        chk("R12 enable restarts", irq, 0);
        tick1();
        chk("R12 expiry after enable", irq, 1);

        // R8 / R9: software reset and external pin
        wr(8'h00, MK | M_XE | M_PH);
        chk("R9 idle low pol high", ext_rst, 0);
        base = rst_cnt;
        wr(8'h14, 32'h1208);
        chk("R8 bad swrst ignored", rst_cnt - base, 0);
        chk("R9 no pulse bad swrst", ext_rst, 0);
        wr(8'h14, 32'h1209);
        chk("R8 swrst while disabled", rst_cnt - base, 1);
        chk("R9 pin active high", ext_rst, 1);
        ticks(PT - 1);
        chk("R9 still active", ext_rst, 1);
        tick1();
        chk("R9 pulse ends", ext_rst, 0);

        wr(8'h00, MK | M_XE);
        chk("R9 idle high pol low", ext_rst, 1);
        wr(8'h14, 32'h1209);
        chk("R9 pin active low", ext_rst, 0);
        ticks(PT);
        chk("R9 low pulse ends", ext_rst, 1);

        wr(8'h00, MK | M_PH);
        wr(8'h14, 32'h1209);
        chk("R9 pin disabled stays idle", ext_rst, 0);
        chk("R8 request counted", rst_cnt - base, 3);

        setup(1, M_EN | M_XE | M_PH);
        ticks(UT);
        chk("R9 expiry drives pin", ext_rst, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule